// File: doc/BRIEF.md
# Radix-4 Booth Iterative Multiply-Accumulate Unit

This block is a sequential multiplier that produces the low WIDTH bits of the product of two WIDTH-bit operands, with an optional accumulate mode that adds a third operand to that product. A caller raises `start` for one cycle with the operands and the accumulate choice. The unit then runs, raising `busy`, and signals completion with a one-cycle `done` pulse while `result` carries the answer. Because only the low word is returned, the same answer serves signed and unsigned operands.

Each iteration recodes two multiplier bits with radix-4 Booth encoding. The recoder looks at the two current bits and the high bit of the previous pair, and picks one of five terms: 0, +M, +2M, -M or -2M, where M is the multiplicand. The term is added into a running sum. After each step the multiplicand moves two places left and the multiplier two places right. When the unshifted multiplier bits that remain and the pending Booth carry are all zero, the operation stops early. A full operand never needs more than WIDTH/2 steps, which is 16 for the default 32 bits. In accumulate mode the running sum starts at the accumulator input rather than zero.

Top module: `radix4_mac`

## Requirements
- R1: With `acc_en` low at the start cycle, `result` during the `done` cycle equals (op_a * op_b) mod 2^WIDTH.
- R2: With `acc_en` high at the start cycle, `result` during the `done` cycle equals (op_a * op_b + acc_in) mod 2^WIDTH.
- R3: The unit needs k busy cycles, and `done` is high in the k-th cycle after the start edge. k is the smallest k >= 1 for which op_b shifted right by 2k is zero and bit 2k-1 of op_b (the Booth carry) is zero. When no such k exists, k is WIDTH/2.
- R4: No operation has more than WIDTH/2 busy cycles.
- R5: When op_b is zero, `done` comes one cycle after the start edge. `result` then equals acc_in in accumulate mode and zero otherwise.
- R6: `done` is high for exactly one cycle, and `busy` is low while `done` is high.
- R7: A `start` raised while `busy` is high is ignored. Operands, mode and latency of the running operation stay unchanged, and no extra `done` follows.
- R8: `busy` is high from the cycle after an accepted `start` until the cycle before `done`.
- R9: After `done`, `result` holds its value until the next accepted `start`.
- R10: After reset, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_a | input | WIDTH | Multiplicand |
| op_b | input | WIDTH | Multiplier, recoded two bits per step |
| acc_in | input | WIDTH | Addend for accumulate mode |
| acc_en | input | 1 | Selects multiply-accumulate when high at start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | WIDTH | Low WIDTH bits of the product or sum |

## Verification
The bench builds the unit with its defaults: WIDTH of 32 and early exit enabled. With these values every latency from one to sixteen steps can be reached. The random multipliers are masked to a random bit length so that each early-exit point is exercised, including operands whose top pair needs a trailing Booth carry step. Directed cases cover a zero multiplier in both modes, all-ones operands that wrap modulo 2^32, a start raised during a running operation, and holding of the result after completion.

// File: rtl/mac_pkg.sv
package mac_pkg;
   // Booth term choice for one radix-4 digit
   typedef enum logic [2:0] {
      TERM_ZERO = 3'd0,
      TERM_POS1 = 3'd1,
      TERM_POS2 = 3'd2,
      TERM_NEG1 = 3'd3,
      TERM_NEG2 = 3'd4
   } term_sel_e;
endpackage

// File: rtl/booth_digit_dec.sv
module booth_digit_dec
   import mac_pkg::*;
(
   input  logic [2:0] triplet,   // {bit1, bit0, previous high bit}
   output term_sel_e  sel
);
   always_comb begin
      unique case (triplet)
         3'b000, 3'b111: sel = TERM_ZERO;
         3'b001, 3'b010: sel = TERM_POS1;
         3'b011:         sel = TERM_POS2;
         3'b100:         sel = TERM_NEG2;
         default:        sel = TERM_NEG1;  // 101, 110
      endcase
   end
endmodule

// File: rtl/booth_term_gen.sv
module booth_term_gen
   import mac_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] mcand,
   input  term_sel_e        sel,
   output logic [WIDTH-1:0] term
);
   logic [WIDTH-1:0] dbl;
   assign dbl = {mcand[WIDTH-2:0], 1'b0};

   always_comb begin
      unique case (sel)
         TERM_POS1: term = mcand;
         TERM_POS2: term = dbl;
         TERM_NEG1: term = ~mcand + 1'b1;
         TERM_NEG2: term = ~dbl + 1'b1;
         default:   term = '0;
      endcase
   end
endmodule

// File: rtl/mac_iter_ctrl.sv
module mac_iter_ctrl #(
   parameter int WIDTH      = 32,
   parameter bit EARLY_EXIT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,      // accepted start
   input  logic rest_zero,   // unshifted multiplier bits beyond this pair are zero
   input  logic carry_next,  // Booth carry into the next pair
   output logic busy,
   output logic done,
   output logic last
);
   localparam int STEPS = WIDTH / 2;
   localparam int CW    = $clog2(STEPS) + 1;

   logic [CW-1:0] step_q;
   logic          busy_q;
   logic          done_q;
   logic          cap_hit;
   logic          drained;

   assign cap_hit = (step_q == CW'(STEPS - 1));

   generate
      if (EARLY_EXIT) begin : g_early
         assign drained = rest_zero & ~carry_next;
      end else begin : g_fixed
         assign drained = 1'b0;
      end
   endgenerate

   assign last = busy_q & (cap_hit | drained);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         step_q <= '0;
      end else begin
         done_q <= last;
         if (launch) begin
            busy_q <= 1'b1;
            step_q <= '0;
         end else if (busy_q) begin
            if (last) begin
               busy_q <= 1'b0;
            end else begin
               step_q <= step_q + 1'b1;
            end
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
endmodule

// File: rtl/radix4_mac.sv
module radix4_mac
   import mac_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter bit EARLY_EXIT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [WIDTH-1:0] acc_in,
   input  logic             acc_en,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] result
);
   generate
      if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
         $error("radix4_mac: WIDTH must be even and at least 4");
      end
   endgenerate

   logic [WIDTH-1:0] mcand_q;
   logic [WIDTH-1:0] mplier_q;
   logic             prev_q;
   logic [WIDTH-1:0] sum_q;
   logic [WIDTH-1:0] term;
   term_sel_e        sel;
   logic             launch;
   logic             last;
   logic             busy_i;
   logic             rest_zero;

   assign launch    = start & ~busy_i;
   assign rest_zero = (mplier_q[WIDTH-1:2] == '0);

   booth_digit_dec u_dec (
      .triplet ({mplier_q[1:0], prev_q}),
      .sel     (sel)
   );

   booth_term_gen #(.WIDTH(WIDTH)) u_term (
      .mcand (mcand_q),
      .sel   (sel),
      .term  (term)
   );

   mac_iter_ctrl #(.WIDTH(WIDTH), .EARLY_EXIT(EARLY_EXIT)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (launch),
      .rest_zero  (rest_zero),
      .carry_next (mplier_q[1]),
      .busy       (busy_i),
      .done       (done),
      .last       (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q  <= '0;
         mplier_q <= '0;
         prev_q   <= 1'b0;
         sum_q    <= '0;
      end else if (launch) begin
         mcand_q  <= op_a;
         mplier_q <= op_b;
         prev_q   <= 1'b0;
         sum_q    <= acc_en ? acc_in : '0;
      end else if (busy_i) begin
         sum_q    <= sum_q + term;
         mcand_q  <= {mcand_q[WIDTH-3:0], 2'b00};
         mplier_q <= {2'b00, mplier_q[WIDTH-1:2]};
         prev_q   <= mplier_q[1];
      end
   end

   assign busy   = busy_i;
   assign result = sum_q;
endmodule

// File: rtl/mac_chk.sv
module mac_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [WIDTH-1:0] op_b,
   input logic [WIDTH-1:0] acc_in,
   input logic             acc_en,
   input logic             busy,
   input logic             done,
   input logic [WIDTH-1:0] result
);
   localparam int STEPS = WIDTH / 2;
   localparam int CW    = $clog2(STEPS) + 2;

   logic [CW-1:0] run_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_cnt <= '0;
      else if (busy) run_cnt <= run_cnt + 1'b1;
      else           run_cnt <= '0;
   end

   // R4
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_cnt < CW'(STEPS)));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R5
   zero_mplier_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op_b == '0) |-> ##2 (done && result == $past(acc_en ? acc_in : '0, 2)));

   // R9
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(result));

   // R8
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

bind radix4_mac mac_chk #(.WIDTH(WIDTH)) u_mac_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .op_b   (op_b),
   .acc_in (acc_in),
   .acc_en (acc_en),
   .busy   (busy),
   .done   (done),
   .result (result)
);

// File: tb/tb_radix4_mac.sv
module tb_radix4_mac;
   localparam int W     = 32;
   localparam int STEPS = W / 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] op_a = '0, op_b = '0, acc_in = '0;
   logic         acc_en = 1'b0;
   logic         busy, done;
   logic [W-1:0] result;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   radix4_mac #(.WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
      .acc_in(acc_in), .acc_en(acc_en), .busy(busy), .done(done), .result(result)
   );

   function automatic int exp_lat(input logic [W-1:0] b);
      logic [63:0] bb;
      bb = {32'b0, b};
      for (int k = 1; k <= STEPS; k++) begin
         if ((bb >> (2 * k)) == 64'd0 && !bb[2 * k - 1]) return k;
      end
      return STEPS;
   endfunction

   function automatic logic [W-1:0] exp_res(input logic [W-1:0] a, b, c, input logic en);
      logic [W-1:0] p;
      p = a * b;
      return en ? p + c : p;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one operation; inject = raise start again mid-run with junk operands
   task automatic run_op(input logic [W-1:0] a, b, c, input logic en, input bit inject);
      int n;
      logic [W-1:0] er;
      int el;
      er = exp_res(a, b, c, en);
      el = exp_lat(b);
      @(negedge clk);
      start = 1'b1; op_a = a; op_b = b; acc_in = c; acc_en = en;
      @(negedge clk);
      start = 1'b0;
      // R8: busy after accepted start
      chk(busy == 1'b1, "R8 busy after start", 64'(busy), 64'd1);
      if (inject) begin
         start = 1'b1; op_a = ~a; op_b = b ^ 32'h5A5A_0F0F; acc_in = ~c; acc_en = ~en;
      end
      n = 0;
      while (n < 40) begin
         @(negedge clk);
         start = 1'b0;
         n++;
         if (done) break;
         if (!busy) break;
      end
      if (n >= 40) begin
         chk(1'b0, "watchdog op", 64'(n), 64'(el));
      end
      // R6: busy low during done
      chk(done && !busy, "R6 done with busy low", 64'({done, busy}), 64'b10);
      if (inject) chk(result == er, "R7 start while busy ignored (result)", 64'(result), 64'(er));
      else if (en) chk(result == er, "R2 multiply-accumulate result", 64'(result), 64'(er));
      else         chk(result == er, "R1 multiply result", 64'(result), 64'(er));
      // R3 / R4 / R7 latency
      if (inject) chk(n == el, "R7 latency with ignored start", 64'(n), 64'(el));
      else        chk(n == el, "R3 data-dependent latency", 64'(n), 64'(el));
      chk(n <= STEPS, "R4 latency bound", 64'(n), 64'(STEPS));
      @(negedge clk);
      chk(!done, "R6 done one cycle", 64'(done), 64'd0);
      if (inject) chk(!busy, "R7 no second operation", 64'(busy), 64'd0);
   endtask

   initial begin
      int rnd_ops;
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] held;
      void'($urandom(32'hC0FFEE));
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(busy == 0 && done == 0 && result == 0, "R10 reset state",
          64'({busy, done, result}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 zero multiplier, both modes
      run_op(32'h1234_5678, 32'd0, 32'hDEAD_BEEF, 1'b1, 1'b0);
      chk(result == 32'hDEAD_BEEF, "R5 zero multiplier accumulate", 64'(result), 64'hDEADBEEF);
      run_op(32'h1234_5678, 32'd0, 32'hDEAD_BEEF, 1'b0, 1'b0);
      chk(result == 32'd0, "R5 zero multiplier plain", 64'(result), 64'd0);
      // directed corner cases
      run_op(32'd7, 32'd1, 32'd0, 1'b0, 1'b0);
      run_op(32'd9, 32'd3, 32'd0, 1'b0, 1'b0);            // carry forces step 2
      run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 1'b0, 1'b0);
      run_op(32'hFFFF_FFFF, 32'd2, 32'hFFFF_FFFF, 1'b1, 1'b0);
      run_op(32'h0000_0003, 32'h8000_0000, 32'd5, 1'b1, 1'b0);
      run_op(32'h8765_4321, 32'h4000_0000, 32'd0, 1'b0, 1'b0);
      // R7 start while busy
      run_op(32'h0BAD_F00D, 32'h00FF_00FF, 32'h1111_2222, 1'b1, 1'b1);
      run_op(32'h0000_1234, 32'd2, 32'd3, 1'b0, 1'b1);
      // R9 result holds after done
      held = result;
      repeat (4) @(negedge clk);
      chk(result == held, "R9 result held while idle", 64'(result), 64'(held));

      // random mix with random multiplier bit length
      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] a, b, c;
         logic [63:0]  mask;
         int           sh;
         sh   = int'($urandom_range(0, W));
         mask = (64'd1 << sh) - 64'd1;
         a = $urandom;
         b = $urandom & mask[W-1:0];
         c = $urandom;
         run_op(a, b, c, 1'($urandom_range(0, 1)), (i % 13) == 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule